// File: doc/BRIEF.md
# Dual-Path Interrupt Mask Bank

This block keeps a set of sticky interrupt status flags and two independent sets of mask registers, one per interrupt output. A system-management output and a non-maskable/IRQ output are both driven from the same status flags. Each output goes high while at least one status flag is set whose mask bit for that output is zero. The flags are grouped into a low group of up to eight sources and a high group of up to seven sources. A one-cycle event pulse sets a flag, and a flag clears only when software writes a one to its bit.

Software reaches every register over a simple byte-wide bus. The bus has an address, a write strobe, write data and combinational read data. Two mask-register bits have extra jobs. Bit 7 of the high SMI mask register drives a reset-enable output. Writing a one to bit 7 of the high NMI mask register starts an active-low chassis-clear pulse that lasts a set number of clock cycles. That bit reads back as one while the pulse runs and clears itself when the pulse ends. The default pulse length is 20 ms at 200 MHz.

Top module: `irq_mask_bank`

## Requirements
- R1: After reset the low and high SMI masks (43h, 44h) and the low NMI mask (45h) read 00h, and the high NMI mask (46h) reads 40h. All status flags read zero, smi_o, nmi_o and reset_en_o are low, and clr_n_o is high.
- R2: A one on src_evt_i for one cycle sets the matching status flag, and the flag stays set. Source bits 0 to 7 read at 41h, bits 0 to 7. Source bits 8 to 14 read at 42h, bits 0 to 6.
- R3: Writing to a status address clears each flag whose written bit is one and leaves the other flags unchanged. If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R4: smi_o is high in the cycle after a status flag becomes set if that flag's SMI mask bit is zero. Low flags use 43h bits 0 to 7 and high flags use 44h bits 0 to 6. A mask bit of one keeps the flag out of smi_o.
- R5: nmi_o is formed the same way from 45h bits 0 to 7 and 46h bits 0 to 6. Because 46h resets to 40h, source 14 (the external SMI input) is kept out of nmi_o by default.
- R6: Mask registers read back what was written. A change to a mask alters the outputs from the next cycle on and does not change any status flag.
- R7: reset_en_o follows 44h bit 7, and that bit masks no source.
- R8: A write of one to 46h bit 7 while no pulse is running drives clr_n_o low for exactly PULSE_CYCLES cycles, starting the cycle after the write.
- R9: 46h bit 7 reads one while clr_n_o is low and zero after the pulse ends.
- R10: A write of one to 46h bit 7 during a running pulse does not restart or lengthen the pulse.
- R11: Addresses outside 41h to 46h read 00h, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| src_evt_i | input | N_LO+N_HI | One-cycle status event pulses |
| smi_o | output | 1 | System-management interrupt |
| nmi_o | output | 1 | NMI/IRQ interrupt |
| reset_en_o | output | 1 | Reset-function enable |
| clr_n_o | output | 1 | Active-low chassis-clear pulse |

## Verification
The event-to-output properties assume that no register write lands in the same cycle as the event they check, since a mask write in that cycle could legitimately hide the event. The stimulus therefore keeps event pulses and bus writes in separate cycles, except for one deliberate cycle that tests the set-over-clear rule. The pulse checks assume a short PULSE_CYCLES in the bench. The second chassis-clear write is placed inside the running pulse so the pulse's end can be timed against the first write.

// File: rtl/imb_pkg.sv
package imb_pkg;
   localparam logic [7:0] ADDR_STAT_LO = 8'h41;
   localparam logic [7:0] ADDR_STAT_HI = 8'h42;
   localparam logic [7:0] ADDR_SMI_LO  = 8'h43;
   localparam logic [7:0] ADDR_SMI_HI  = 8'h44;
   localparam logic [7:0] ADDR_NMI_LO  = 8'h45;
   localparam logic [7:0] ADDR_NMI_HI  = 8'h46;
   localparam int         CTRL_BIT     = 7;
endpackage

// File: rtl/imb_sticky_status.sv
module imb_sticky_status #(
   parameter int         W    = 8,
   parameter logic [7:0] ADDR = 8'h41
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic [7:0]   addr_i,
   input  logic [7:0]   wdata_i,
   input  logic [W-1:0] evt_i,
   output logic [W-1:0] stat_o
);
   logic [W-1:0] clr;

   initial begin
      if (W < 1 || W > 8) $error("imb_sticky_status: W out of range");
   end

   assign clr = (wr_en_i && addr_i == ADDR) ? wdata_i[W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_o <= '0;
      else        stat_o <= (stat_o & ~clr) | evt_i;
   end
endmodule

// File: rtl/imb_mask_reg.sv
module imb_mask_reg #(
   parameter int         W    = 8,
   parameter logic [7:0] ADDR = 8'h43,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic [7:0]   addr_i,
   input  logic [7:0]   wdata_i,
   output logic [W-1:0] mask_o
);
   initial begin
      if (W < 1 || W > 8) $error("imb_mask_reg: W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mask_o <= RST;
      else if (wr_en_i && addr_i == ADDR)  mask_o <= wdata_i[W-1:0];
   end
endmodule

// File: rtl/imb_pulse_timer.sv
module imb_pulse_timer #(
   parameter int PULSE_CYCLES = 4_000_000,
   parameter int CNT_W        = $clog2(PULSE_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             busy_o,
   output logic [CNT_W-1:0] cnt_o
);
   initial begin
      if (PULSE_CYCLES < 1) $error("imb_pulse_timer: PULSE_CYCLES must be positive");
      if ((64'd1 << CNT_W) <= 64'(PULSE_CYCLES)) $error("imb_pulse_timer: CNT_W too narrow");
   end

   assign busy_o = (cnt_o != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_o <= '0;
      else if (start_i && !busy_o)  cnt_o <= CNT_W'(PULSE_CYCLES);
      else if (busy_o)              cnt_o <= cnt_o - CNT_W'(1);
   end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
   import imb_pkg::*;
#(
   parameter int N_LO         = 8,
   parameter int N_HI         = 7,
   parameter int PULSE_CYCLES = 4_000_000,
   parameter int CNT_W        = $clog2(PULSE_CYCLES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en_i,
   input  logic [7:0]           addr_i,
   input  logic [7:0]           wdata_i,
   output logic [7:0]           rdata_o,
   input  logic [N_LO+N_HI-1:0] src_evt_i,
   output logic                 smi_o,
   output logic                 nmi_o,
   output logic                 reset_en_o,
   output logic                 clr_n_o
);
   localparam int         NSRC    = N_LO + N_HI;
   localparam logic [N_HI-1:0] NMI_HI_RST = N_HI'(1) << (N_HI - 1);

   logic [N_LO-1:0] stat_lo;
   logic [N_HI-1:0] stat_hi;
   logic [7:0]      smi_lo, smi_hi, nmi_lo;
   logic [N_HI-1:0] nmi_hi;
   logic [NSRC-1:0] stat_vec, smi_mask_vec, nmi_mask_vec;
   logic            clr_busy, clr_start;
   logic [CNT_W-1:0] clr_cnt;

   generate
      if (N_LO < 1 || N_LO > 8) begin : g_bad_lo
         initial $error("irq_mask_bank: N_LO must be 1..8");
      end
      if (N_HI < 1 || N_HI > CTRL_BIT) begin : g_bad_hi
         initial $error("irq_mask_bank: N_HI must be 1..7");
      end
   endgenerate

   imb_sticky_status #(.W(N_LO), .ADDR(ADDR_STAT_LO)) u_stat_lo (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .evt_i(src_evt_i[N_LO-1:0]), .stat_o(stat_lo));

   imb_sticky_status #(.W(N_HI), .ADDR(ADDR_STAT_HI)) u_stat_hi (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .evt_i(src_evt_i[NSRC-1:N_LO]), .stat_o(stat_hi));

   imb_mask_reg #(.W(8), .ADDR(ADDR_SMI_LO), .RST(8'h00)) u_smi_lo (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .mask_o(smi_lo));

   imb_mask_reg #(.W(8), .ADDR(ADDR_SMI_HI), .RST(8'h00)) u_smi_hi (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .mask_o(smi_hi));

   imb_mask_reg #(.W(8), .ADDR(ADDR_NMI_LO), .RST(8'h00)) u_nmi_lo (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .mask_o(nmi_lo));

   imb_mask_reg #(.W(N_HI), .ADDR(ADDR_NMI_HI), .RST(NMI_HI_RST)) u_nmi_hi (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .mask_o(nmi_hi));

   assign clr_start = wr_en_i && (addr_i == ADDR_NMI_HI) && wdata_i[CTRL_BIT];

   imb_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES), .CNT_W(CNT_W)) u_clr_timer (
      .clk(clk), .rst_n(rst_n), .start_i(clr_start),
      .busy_o(clr_busy), .cnt_o(clr_cnt));

   assign stat_vec     = {stat_hi, stat_lo};
   assign smi_mask_vec = {smi_hi[N_HI-1:0], smi_lo[N_LO-1:0]};
   assign nmi_mask_vec = {nmi_hi, nmi_lo[N_LO-1:0]};

   assign smi_o      = |(stat_vec & ~smi_mask_vec);
   assign nmi_o      = |(stat_vec & ~nmi_mask_vec);
   assign reset_en_o = smi_hi[CTRL_BIT];
   assign clr_n_o    = !clr_busy;

   always_comb begin
      case (addr_i)
         ADDR_STAT_LO: rdata_o = 8'(stat_lo);
         ADDR_STAT_HI: rdata_o = 8'(stat_hi);
         ADDR_SMI_LO:  rdata_o = smi_lo;
         ADDR_SMI_HI:  rdata_o = smi_hi;
         ADDR_NMI_LO:  rdata_o = nmi_lo;
         ADDR_NMI_HI:  rdata_o = {clr_busy, 7'(nmi_hi)};
         default:      rdata_o = 8'h00;
      endcase
   end
endmodule

// File: rtl/imb_checker.sv
module imb_checker
   import imb_pkg::*;
#(
   parameter int NSRC  = 15,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en_i,
   input logic [7:0]       addr_i,
   input logic [7:0]       wdata_i,
   input logic [7:0]       rdata_o,
   input logic [NSRC-1:0]  src_evt_i,
   input logic             smi_o,
   input logic             nmi_o,
   input logic             reset_en_o,
   input logic             clr_n_o,
   input logic [NSRC-1:0]  smi_mask_vec,
   input logic [NSRC-1:0]  nmi_mask_vec,
   input logic [CNT_W-1:0] clr_cnt
);
   AST_STICKY_SMI: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && smi_o) |=> smi_o); // R2

   AST_SMI_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && |(src_evt_i & ~smi_mask_vec)) |=> smi_o); // R4

   AST_NMI_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && |(src_evt_i & ~nmi_mask_vec)) |=> nmi_o); // R5

   AST_RESET_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == ADDR_SMI_HI) |=> (reset_en_o == $past(wdata_i[CTRL_BIT]))); // R7

   AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == ADDR_NMI_HI && wdata_i[CTRL_BIT] && clr_n_o) |=> !clr_n_o); // R8

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cnt > CNT_W'(1)) |=> (clr_cnt == $past(clr_cnt) - CNT_W'(1))); // R10

   always_comb begin
      if (rst_n) begin
         AST_BUSY_READ: assert (!(addr_i == ADDR_NMI_HI && !clr_n_o) || rdata_o[CTRL_BIT]); // R9
         AST_UNMAPPED_ZERO: assert (!(addr_i < ADDR_STAT_LO || addr_i > ADDR_NMI_HI) || rdata_o == 8'h00); // R11
      end
   end
endmodule

bind irq_mask_bank imb_checker #(.NSRC(NSRC), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
   .wdata_i(wdata_i), .rdata_o(rdata_o), .src_evt_i(src_evt_i),
   .smi_o(smi_o), .nmi_o(nmi_o), .reset_en_o(reset_en_o), .clr_n_o(clr_n_o),
   .smi_mask_vec(smi_mask_vec), .nmi_mask_vec(nmi_mask_vec), .clr_cnt(clr_cnt));

// File: tb/irq_mask_bank_tb.sv
`timescale 1ns/100ps
module irq_mask_bank_tb;
   localparam int N_LO = 8;
   localparam int N_HI = 7;
   localparam int PULSE = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en_i = 1'b0;
   logic [7:0]        addr_i = 8'h00;
   logic [7:0]        wdata_i = 8'h00;
   logic [7:0]        rdata_o;
   logic [N_LO+N_HI-1:0] src_evt_i = '0;
   logic smi_o, nmi_o, reset_en_o, clr_n_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      bit         is_pins;
      logic [7:0] addr;
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t sb_q[$];

   always #2.5 clk = ~clk;

   irq_mask_bank #(.N_LO(N_LO), .N_HI(N_HI), .PULSE_CYCLES(PULSE)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .rdata_o(rdata_o), .src_evt_i(src_evt_i),
      .smi_o(smi_o), .nmi_o(nmi_o), .reset_en_o(reset_en_o), .clr_n_o(clr_n_o));

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         wait (sb_q.size() > 0);
         #0.2;
         begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            act = it.is_pins ? {4'h0, smi_o, nmi_o, reset_en_o, clr_n_o} : rdata_o;
            checks++;
            if (act !== it.exp) begin
               failures++;
               $display("FAIL %s %s addr=%02h actual=%02h expected=%02h",
                        it.tag, it.is_pins ? "pins" : "read", it.addr, act, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      wr_en_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic evt(input logic [N_LO+N_HI-1:0] v);
      src_evt_i = v;
      @(negedge clk);
      src_evt_i = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
      item_t it;
      addr_i = a;
      it.is_pins = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      #0.4;
   endtask

   // pins = {smi, nmi, reset_en, clr_n}
   task automatic chk_pins(input logic [3:0] e, input string tag);
      item_t it;
      it.is_pins = 1'b1; it.addr = addr_i; it.exp = {4'h0, e}; it.tag = tag;
      sb_q.push_back(it);
      #0.4;
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_rd(8'h43, 8'h00, "R1"); chk_rd(8'h44, 8'h00, "R1"); chk_rd(8'h45, 8'h00, "R1");
      idle(1);
      chk_rd(8'h46, 8'h40, "R1"); chk_rd(8'h41, 8'h00, "R1"); chk_pins(4'b0001, "R1");
      idle(1);

      // R2 R4 R5: event on source 2
      evt(15'h0004);
      chk_pins(4'b1101, "R4"); chk_rd(8'h41, 8'h04, "R2");
      idle(3);
      chk_pins(4'b1101, "R2");

      // R3 write-one-to-clear
      wr(8'h41, 8'h01);
      chk_rd(8'h41, 8'h04, "R3");
      wr(8'h41, 8'h04);
      chk_rd(8'h41, 8'h00, "R3"); chk_pins(4'b0001, "R3");

      // R5 source 14 masked from NMI by default
      evt(15'h4000);
      chk_pins(4'b1001, "R5"); chk_rd(8'h42, 8'h40, "R2");

      // R6 mask changes, status untouched
      wr(8'h44, 8'h40);
      chk_pins(4'b0001, "R6"); chk_rd(8'h44, 8'h40, "R6"); chk_rd(8'h42, 8'h40, "R6");
      wr(8'h46, 8'h00);
      chk_pins(4'b0101, "R5");
      wr(8'h44, 8'h00);
      chk_pins(4'b1101, "R6");
      wr(8'h42, 8'h40);
      chk_pins(4'b0001, "R3");

      // R4 low SMI mask, R5 low NMI mask
      wr(8'h43, 8'hFF);
      evt(15'h0001);
      chk_pins(4'b0101, "R4");
      wr(8'h45, 8'hFF);
      chk_pins(4'b0001, "R5");
      wr(8'h43, 8'h00);
      chk_pins(4'b1001, "R4");
      wr(8'h41, 8'hFF);
      wr(8'h45, 8'h00);
      chk_pins(4'b0001, "R3");

      // R3 set wins over simultaneous clear
      src_evt_i = 15'h0002; wr_en_i = 1'b1; addr_i = 8'h41; wdata_i = 8'h02;
      @(negedge clk);
      src_evt_i = '0; wr_en_i = 1'b0;
      chk_rd(8'h41, 8'h02, "R3");
      wr(8'h41, 8'h02);
      chk_rd(8'h41, 8'h00, "R3");

      // R7 reset enable does not mask
      wr(8'h44, 8'h80);
      chk_pins(4'b0011, "R7"); chk_rd(8'h44, 8'h80, "R7");
      evt(15'h0100);
      chk_pins(4'b1111, "R7");
      wr(8'h42, 8'h01);
      wr(8'h44, 8'h00);
      chk_pins(4'b0001, "R7");

      // R11 unmapped addresses
      wr(8'h47, 8'hFF);
      chk_rd(8'h47, 8'h00, "R11"); chk_rd(8'h40, 8'h00, "R11");
      idle(1);
      chk_rd(8'h43, 8'h00, "R11"); chk_rd(8'h46, 8'h00, "R11"); chk_pins(4'b0001, "R11");
      idle(1);

      // R8 R9 R10 chassis-clear pulse (capture edge E)
      wr(8'h46, 8'hC0);
      chk_pins(4'b0000, "R8"); chk_rd(8'h46, 8'hC0, "R9");
      idle(5);
      wr(8'h46, 8'hC0);              // captured at E+6, must be ignored
      chk_pins(4'b0000, "R10");
      idle(1);                       // after E+7: last low cycle
      chk_pins(4'b0000, "R8");
      idle(1);                       // after E+8: pulse over
      chk_pins(4'b0001, "R10"); chk_rd(8'h46, 8'h40, "R9");
      idle(2);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule